// File: doc/BRIEF.md
# Multi-Reset Exposure Sequencer

This block sequences one frame of a snapshot pixel array that extends its dynamic range by conditionally resetting bright pixels partway through exposure. A frame-start request begins a global pixel reset. During that reset the comparator output nodes are also precharged. The exposure is then cut into a programmable number of sub-intervals. The first one lasts a programmable base count, and each later one is that count shifted right once more, so every sub-interval is half the one before it by default. Each sub-interval closes with a short window in which the pixel comparators are woken. Inside that window an active-low conditional-reset pulse goes out to the array and the per-pixel decision is latched. The decision latched in one window is forwarded during the next sub-interval. After the last window, the block issues three strobes in a fixed order: charge sharing, then storage-node reset, then charge transfer into the in-pixel memory.

Once the transfer is done, the block scans the stored frame row by row. It drives row and column addresses and two sample strobes per pixel: the signal level first, then the reset level. The scan runs in the background, so a new exposure can be started while the previous frame is still being read out. A single busy output covers the whole span from the accepted start to the final sample.

Top module: `mre_seq`

## Requirements
- R1: A start request seen while no exposure is running drives `pix_rst_n_o` and `prech_n_o` low together for RST_LEN cycles. These cycles begin on the cycle after the request is sampled.
- R2: Sub-interval k (k = 0 for the first) lasts max(1, base >> (K_SHIFT*k)) cycles. The base count and the sub-interval count are captured when the start is accepted.
- R3: Each sub-interval is followed by a 3-cycle window with `cmp_wake_o` high. Within it, `cond_rst_n_o` is low only in the second cycle and `flag_latch_o` is high only in the third cycle.
- R4: `flag_fwd_o` is high during every sub-interval except the first, and also during the charge-share phase. It is low at all other times.
- R5: Right after the last compare window, `share_o`, then `st_rst_o`, then `xfer_o` are each high for XFER_LEN cycles, in that order and with no gap. At most one of these global phases is active at any time.
- R6: The readout starts on the cycle after the last transfer cycle. Each pixel occupies two cycles: `smp_sig_o` in the first and `smp_rst_o` in the second, with the address held. The column advances fastest, from row 0 and column 0 up to row ROWS-1 and column COLS-1.
- R7: `busy_o` is high from the cycle after an accepted start until the last readout cycle, and low when neither an exposure nor a readout is running.
- R8: A start request that arrives while an exposure is running, from the global reset up to the last transfer cycle, has no effect on any output.
- R9: A sub-interval count of 0 behaves as 1, and a count above MAX_INT behaves as MAX_INT.
- R10: A start request accepted during a readout begins a new exposure at once. The readout in progress continues unchanged.
- R11: After reset, all strobes are inactive: the active-low ones are high and the active-high ones are low. Row and column are 0 and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame-start request |
| nint_i | input | $clog2(MAX_INT+1) | Number of sub-intervals (clamped 1..MAX_INT) |
| base_i | input | CNT_W | Length of the first sub-interval in cycles |
| pix_rst_n_o | output | 1 | Global pixel reset, active low |
| prech_n_o | output | 1 | Comparator output precharge, active low |
| cmp_wake_o | output | 1 | Comparator wake (sleep released) |
| cond_rst_n_o | output | 1 | Conditional reset pulse, active low |
| flag_latch_o | output | 1 | Latch the per-pixel reset decision |
| flag_fwd_o | output | 1 | Forward the previous decision flag |
| share_o | output | 1 | Final charge-share strobe |
| st_rst_o | output | 1 | Storage-node reset strobe |
| xfer_o | output | 1 | Charge transfer to storage |
| row_o | output | $clog2(ROWS) | Readout row address |
| col_o | output | $clog2(COLS) | Readout column address |
| smp_sig_o | output | 1 | Signal-level sample strobe |
| smp_rst_o | output | 1 | Reset-level sample strobe |
| busy_o | output | 1 | Exposure or readout in progress |

## Verification
The bench sweeps every sub-interval count from 0 to 9 plus 15, against base counts of 0, 1, 3, 16 and 37. This exercises the clamp at both ends and the floor of one cycle once the shifted base reaches zero. If that floor were missing, some interval would last zero or a wrapped huge number of cycles, so the compare window would come too early or never. A shift off by one interval, or an off-by-one in the last-interval test, moves every later strobe and the whole readout. A start pulsed into the reset, integration, compare and transfer phases would restart the frame if the ignore rule were broken. A start placed in the middle of a readout would corrupt the address sequence if the scanner were tied to the exposure state.

// File: rtl/mre_pkg.sv
package mre_pkg;

    typedef enum logic [2:0] {
        EX_IDLE,
        EX_GRST,
        EX_INTEG,
        EX_CMP,
        EX_SHARE,
        EX_SRST,
        EX_XFER
    } ex_state_e;

    // compare window: wake, conditional reset, latch
    localparam int unsigned CMP_STEPS = 3;

endpackage

// File: rtl/mre_interval_len.sv
module mre_interval_len #(
    parameter int CNT_W   = 16,
    parameter int IDX_W   = 3,
    parameter int K_SHIFT = 1
) (
    input  logic [CNT_W-1:0] base_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [CNT_W-1:0] load_o
);
    logic [CNT_W-1:0] shifted;
    int unsigned      shamt;

    always_comb begin
        shamt   = K_SHIFT * int'(idx_i);
        shifted = base_i >> shamt;
        // length is at least one cycle; counter is loaded with length-1
        load_o  = (shifted == '0) ? '0 : shifted - 1'b1;
    end
endmodule

// File: rtl/mre_expo_ctrl.sv
module mre_expo_ctrl
    import mre_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_INT  = 8,
    parameter int K_SHIFT  = 1,
    parameter int RST_LEN  = 4,
    parameter int XFER_LEN = 2,
    localparam int NI_W    = $clog2(MAX_INT + 1),
    localparam int IDX_W   = (MAX_INT > 1) ? $clog2(MAX_INT) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [NI_W-1:0]  nint_i,
    input  logic [CNT_W-1:0] base_i,
    output logic             pix_rst_n_o,
    output logic             prech_n_o,
    output logic             cmp_wake_o,
    output logic             cond_rst_n_o,
    output logic             flag_latch_o,
    output logic             flag_fwd_o,
    output logic             share_o,
    output logic             st_rst_o,
    output logic             xfer_o,
    output logic             active_o,
    output logic             rd_go_o
);
    typedef struct packed {
        ex_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [CNT_W-1:0] base;
    } ex_regs_t;

    ex_regs_t         r_d, r_q;
    logic [IDX_W-1:0] last_sel;
    logic [IDX_W-1:0] idx_sel;
    logic [CNT_W-1:0] len_load;
    logic             cnt_zero;

    mre_interval_len #(
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W),
        .K_SHIFT(K_SHIFT)
    ) u_len (
        .base_i(r_q.base),
        .idx_i (idx_sel),
        .load_o(len_load)
    );

    always_comb begin
        if (nint_i == '0) begin
            last_sel = '0;
        end else if (nint_i > NI_W'(MAX_INT)) begin
            last_sel = IDX_W'(MAX_INT - 1);
        end else begin
            last_sel = IDX_W'(nint_i - 1'b1);
        end
        idx_sel  = (r_q.st == EX_CMP) ? r_q.idx + IDX_W'(1) : '0;
        cnt_zero = (r_q.cnt == '0);
    end

    always_comb begin
        r_d     = r_q;
        rd_go_o = 1'b0;
        if (!cnt_zero) r_d.cnt = r_q.cnt - 1'b1;
        case (r_q.st)
            EX_IDLE: begin
                if (start_i) begin
                    r_d.st   = EX_GRST;
                    r_d.cnt  = CNT_W'(RST_LEN - 1);
                    r_d.idx  = '0;
                    r_d.last = last_sel;
                    r_d.base = base_i;
                end
            end
            EX_GRST: begin
                if (cnt_zero) begin
                    r_d.st  = EX_INTEG;
                    r_d.cnt = len_load;
                end
            end
            EX_INTEG: begin
                if (cnt_zero) begin
                    r_d.st  = EX_CMP;
                    r_d.cnt = CNT_W'(CMP_STEPS - 1);
                end
            end
            EX_CMP: begin
                if (cnt_zero) begin
                    if (r_q.idx == r_q.last) begin
                        r_d.st  = EX_SHARE;
                        r_d.cnt = CNT_W'(XFER_LEN - 1);
                    end else begin
                        r_d.st  = EX_INTEG;
                        r_d.idx = idx_sel;
                        r_d.cnt = len_load;
                    end
                end
            end
            EX_SHARE: begin
                if (cnt_zero) begin
                    r_d.st  = EX_SRST;
                    r_d.cnt = CNT_W'(XFER_LEN - 1);
                end
            end
            EX_SRST: begin
                if (cnt_zero) begin
                    r_d.st  = EX_XFER;
                    r_d.cnt = CNT_W'(XFER_LEN - 1);
                end
            end
            EX_XFER: begin
                if (cnt_zero) begin
                    r_d.st  = EX_IDLE;
                    rd_go_o = 1'b1;
                end
            end
            default: r_d.st = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: EX_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        pix_rst_n_o  = (r_q.st != EX_GRST);
        prech_n_o    = (r_q.st != EX_GRST);
        cmp_wake_o   = (r_q.st == EX_CMP);
        cond_rst_n_o = !((r_q.st == EX_CMP) && (r_q.cnt == CNT_W'(1)));
        flag_latch_o = (r_q.st == EX_CMP) && cnt_zero;
        flag_fwd_o   = ((r_q.st == EX_INTEG) && (r_q.idx != '0)) || (r_q.st == EX_SHARE);
        share_o      = (r_q.st == EX_SHARE);
        st_rst_o     = (r_q.st == EX_SRST);
        xfer_o       = (r_q.st == EX_XFER);
        active_o     = (r_q.st != EX_IDLE);
    end
endmodule

// File: rtl/mre_readout_scan.sv
module mre_readout_scan #(
    parameter int ROWS     = 32,
    parameter int COLS     = 32,
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             smp_sig_o,
    output logic             smp_rst_o,
    output logic             active_o
);
    typedef struct packed {
        logic             act;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             smp;
    } rd_regs_t;

    rd_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (go_i) begin
            s_d = '{act: 1'b1, default: '0};
        end else if (s_q.act) begin
            s_d.smp = !s_q.smp;
            if (s_q.smp) begin
                if (s_q.col == COL_W'(COLS - 1)) begin
                    s_d.col = '0;
                    if (s_q.row == ROW_W'(ROWS - 1)) begin
                        s_d.row = '0;
                        s_d.act = 1'b0;
                    end else begin
                        s_d.row = s_q.row + 1'b1;
                    end
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign row_o     = s_q.row;
    assign col_o     = s_q.col;
    assign smp_sig_o = s_q.act && !s_q.smp;
    assign smp_rst_o = s_q.act && s_q.smp;
    assign active_o  = s_q.act;
endmodule

// File: rtl/mre_seq.sv
module mre_seq #(
    parameter int ROWS     = 32,
    parameter int COLS     = 32,
    parameter int CNT_W    = 16,
    parameter int MAX_INT  = 8,
    parameter int K_SHIFT  = 1,
    parameter int RST_LEN  = 4,
    parameter int XFER_LEN = 2,
    localparam int NI_W    = $clog2(MAX_INT + 1),
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [NI_W-1:0]  nint_i,
    input  logic [CNT_W-1:0] base_i,
    output logic             pix_rst_n_o,
    output logic             prech_n_o,
    output logic             cmp_wake_o,
    output logic             cond_rst_n_o,
    output logic             flag_latch_o,
    output logic             flag_fwd_o,
    output logic             share_o,
    output logic             st_rst_o,
    output logic             xfer_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             smp_sig_o,
    output logic             smp_rst_o,
    output logic             busy_o
);
    logic expo_active;
    logic rd_active;
    logic rd_go;

    mre_expo_ctrl #(
        .CNT_W   (CNT_W),
        .MAX_INT (MAX_INT),
        .K_SHIFT (K_SHIFT),
        .RST_LEN (RST_LEN),
        .XFER_LEN(XFER_LEN)
    ) u_expo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .nint_i      (nint_i),
        .base_i      (base_i),
        .pix_rst_n_o (pix_rst_n_o),
        .prech_n_o   (prech_n_o),
        .cmp_wake_o  (cmp_wake_o),
        .cond_rst_n_o(cond_rst_n_o),
        .flag_latch_o(flag_latch_o),
        .flag_fwd_o  (flag_fwd_o),
        .share_o     (share_o),
        .st_rst_o    (st_rst_o),
        .xfer_o      (xfer_o),
        .active_o    (expo_active),
        .rd_go_o     (rd_go)
    );

    mre_readout_scan #(
        .ROWS(ROWS),
        .COLS(COLS)
    ) u_scan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .go_i     (rd_go),
        .row_o    (row_o),
        .col_o    (col_o),
        .smp_sig_o(smp_sig_o),
        .smp_rst_o(smp_rst_o),
        .active_o (rd_active)
    );

    assign busy_o = expo_active || rd_active;
endmodule

// File: rtl/mre_seq_chk.sv
module mre_seq_chk #(
    parameter int ROW_W = 5,
    parameter int COL_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             pix_rst_n_o,
    input logic             cmp_wake_o,
    input logic             cond_rst_n_o,
    input logic             flag_latch_o,
    input logic             share_o,
    input logic             st_rst_o,
    input logic             xfer_o,
    input logic [ROW_W-1:0] row_o,
    input logic [COL_W-1:0] col_o,
    input logic             smp_sig_o,
    input logic             smp_rst_o,
    input logic             busy_o
);
    p_grst_needs_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pix_rst_n_o) |-> $past(start_i));

    p_cond_in_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cond_rst_n_o |-> (cmp_wake_o && $past(cmp_wake_o)));

    p_latch_after_cond_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_latch_o |-> $past(!cond_rst_n_o));

    p_srst_after_share_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_rst_o) |-> $past(share_o));

    p_xfer_after_srst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(xfer_o) |-> $past(st_rst_o));

    p_phase_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({!pix_rst_n_o, cmp_wake_o, share_o, st_rst_o, xfer_o}));

    p_scan_after_xfer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(xfer_o) |-> (smp_sig_o && row_o == '0 && col_o == '0));

    p_rst_smp_follows_sig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_rst_o |-> ($past(smp_sig_o) && $stable(row_o) && $stable(col_o)));

    p_busy_cover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_sig_o || smp_rst_o || !pix_rst_n_o || cmp_wake_o || share_o || xfer_o) |-> busy_o);

    p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && (cmp_wake_o || share_o || st_rst_o)) |=> pix_rst_n_o);
endmodule

bind mre_seq mre_seq_chk #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pix_rst_n_o (pix_rst_n_o),
    .cmp_wake_o  (cmp_wake_o),
    .cond_rst_n_o(cond_rst_n_o),
    .flag_latch_o(flag_latch_o),
    .share_o     (share_o),
    .st_rst_o    (st_rst_o),
    .xfer_o      (xfer_o),
    .row_o       (row_o),
    .col_o       (col_o),
    .smp_sig_o   (smp_sig_o),
    .smp_rst_o   (smp_rst_o),
    .busy_o      (busy_o)
);

// File: tb/tb_mre_seq.sv
`timescale 1ns/1ps
module tb_mre_seq;
    localparam int R    = 4;
    localparam int C    = 4;
    localparam int RL   = 4;
    localparam int XL   = 2;
    localparam int KS   = 1;
    localparam int MAXI = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [3:0]  nint_i;
    logic [15:0] base_i;
    logic pix_rst_n_o, prech_n_o, cmp_wake_o, cond_rst_n_o, flag_latch_o;
    logic flag_fwd_o, share_o, st_rst_o, xfer_o, smp_sig_o, smp_rst_o, busy_o;
    logic [1:0] row_o, col_o;

    always #10 clk = ~clk;

    mre_seq #(.ROWS(R), .COLS(C), .RST_LEN(RL), .XFER_LEN(XL), .K_SHIFT(KS), .MAX_INT(MAXI)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .nint_i(nint_i), .base_i(base_i),
        .pix_rst_n_o(pix_rst_n_o), .prech_n_o(prech_n_o), .cmp_wake_o(cmp_wake_o),
        .cond_rst_n_o(cond_rst_n_o), .flag_latch_o(flag_latch_o), .flag_fwd_o(flag_fwd_o),
        .share_o(share_o), .st_rst_o(st_rst_o), .xfer_o(xfer_o), .row_o(row_o), .col_o(col_o),
        .smp_sig_o(smp_sig_o), .smp_rst_o(smp_rst_o), .busy_o(busy_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    int fs[2], fn[2], fb[2];
    bit fv[2];
    int mm[6];
    int mcyc[6];
    logic [15:0] ma[6], me[6];
    string tags[6] = '{"R1", "R2 R3", "R4", "R5", "R6", "R7"};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ilen(int b, int k);
        int l;
        l = b >> (KS * k);
        return (l < 1) ? 1 : l;
    endfunction

    function automatic int clampn(int n);
        if (n < 1) return 1;
        if (n > MAXI) return MAXI;
        return n;
    endfunction

    function automatic int elen(int n, int b);
        int e;
        e = RL;
        for (int k = 0; k < n; k++) e += ilen(b, k) + 3;
        return e + 3 * XL;
    endfunction

    // bit order: xfer, st_rst, share, fwd, latch, cond_n, wake, prech_n, pix_n
    function automatic logic [8:0] ebits(int t, int n, int b);
        logic [8:0] v;
        int p;
        int l;
        v = 9'b000001011;
        if (t < 0) return v;
        if (t < RL) begin v[0] = 1'b0; v[1] = 1'b0; return v; end
        p = RL;
        for (int k = 0; k < n; k++) begin
            l = ilen(b, k);
            if (t < p + l) begin v[5] = (k > 0); return v; end
            p += l;
            if (t < p + 3) begin
                v[2] = 1'b1;
                if (t == p + 1) v[3] = 1'b0;
                if (t == p + 2) v[4] = 1'b1;
                return v;
            end
            p += 3;
        end
        if (t < p + XL) begin v[6] = 1'b1; v[5] = 1'b1; return v; end
        p += XL;
        if (t < p + XL) begin v[7] = 1'b1; return v; end
        p += XL;
        if (t < p + XL) begin v[8] = 1'b1; return v; end
        return v;
    endfunction

    task automatic note(int c, logic [15:0] a, logic [15:0] e);
        if (a !== e) begin
            if (mm[c] == 0) begin ma[c] = a; me[c] = e; mcyc[c] = cyc; end
            mm[c]++;
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            logic [8:0] eb, ab;
            logic [5:0] er, ar;
            logic eby;
            eb  = 9'b000001011;
            er  = '0;
            eby = 1'b0;
            if (fv[0]) eb = ebits(cyc - fs[0], fn[0], fb[0]);
            for (int s = 1; s >= 0; s--) begin
                if (fv[s]) begin
                    int e, rt, ft;
                    e  = elen(fn[s], fb[s]);
                    ft = cyc - fs[s];
                    rt = ft - e;
                    if (rt >= 0 && rt < 2 * R * C)
                        er = {2'(rt / (2 * C)), 2'((rt / 2) % C), (rt % 2) == 0, (rt % 2) == 1};
                    if (ft >= 0 && ft < e + 2 * R * C) eby = 1'b1;
                end
            end
            ab = {xfer_o, st_rst_o, share_o, flag_fwd_o, flag_latch_o, cond_rst_n_o,
                  cmp_wake_o, prech_n_o, pix_rst_n_o};
            ar = {row_o, col_o, smp_sig_o, smp_rst_o};
            note(0, 16'(ab[1:0]), 16'(eb[1:0]));
            note(1, 16'(ab[4:2]), 16'(eb[4:2]));
            note(2, 16'(ab[5]),   16'(eb[5]));
            note(3, 16'(ab[8:6]), 16'(eb[8:6]));
            note(4, 16'(ar),      16'(er));
            note(5, 16'(busy_o),  16'(eby));
        end
    end

    task automatic end_window(string scen);
        for (int c = 0; c < 6; c++) begin
            checks++;
            if (mm[c] != 0) begin
                errors++;
                $display("FAIL %s [%s]: %0d bad cycles, first at cycle %0d actual %h expected %h",
                         tags[c], scen, mm[c], mcyc[c], ma[c], me[c]);
            end
            mm[c] = 0;
        end
    endtask

    task automatic kick(int n, int b, bit acc);
        nint_i  = 4'(n);
        base_i  = 16'(b);
        start_i = 1'b1;
        if (acc) begin
            fs[1] = fs[0]; fn[1] = fn[0]; fb[1] = fb[0]; fv[1] = fv[0];
            fs[0] = cyc + 1; fn[0] = clampn(n); fb[0] = b; fv[0] = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        int ns[11] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 15};
        int bs[5]  = '{0, 1, 3, 16, 37};
        rst_n = 1'b0; start_i = 1'b0; nint_i = '0; base_i = '0;
        fv[0] = 1'b0; fv[1] = 1'b0;
        for (int c = 0; c < 6; c++) mm[c] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle state after reset
        checks++;
        if ({pix_rst_n_o, prech_n_o, cond_rst_n_o} !== 3'b111 ||
            {cmp_wake_o, flag_latch_o, flag_fwd_o, share_o, st_rst_o, xfer_o} !== 6'b0 ||
            {row_o, col_o, smp_sig_o, smp_rst_o, busy_o} !== 7'b0) begin
            errors++;
            $display("FAIL R11 reset state: actual %b %b %b expected 111 000000 0000000",
                {pix_rst_n_o, prech_n_o, cond_rst_n_o},
                {cmp_wake_o, flag_latch_o, flag_fwd_o, share_o, st_rst_o, xfer_o},
                {row_o, col_o, smp_sig_o, smp_rst_o, busy_o});
        end
        mon_en = 1'b1;

        // sweep of counts and bases; counts 0, 9 and 15 exercise R9
        foreach (ns[i]) begin
            foreach (bs[j]) begin
                kick(ns[i], bs[j], 1'b1);
                repeat (elen(clampn(ns[i]), bs[j]) + 2 * R * C + 3) @(negedge clk);
                end_window($sformatf("sweep n=%0d b=%0d%s", ns[i], bs[j],
                           (ns[i] == 0 || ns[i] > MAXI) ? " R9" : ""));
            end
        end

        // R8: starts pulsed into each exposure phase are ignored
        begin
            int e, q;
            e = elen(3, 20);
            kick(3, 20, 1'b1);
            q = 1;
            foreach (bs[j]) begin
                int off;
                off = (j == 0) ? 2 : (j == 1) ? 10 : (j == 2) ? 25 : (j == 3) ? 40 : e - 2;
                repeat (off - q) @(negedge clk);
                kick(5, 7, 1'b0);
                q = off + 1;
            end
            repeat (e + 2 * R * C + 3 - q) @(negedge clk);
            end_window("R8 ignored start");
        end

        // R10: new exposure started during readout
        begin
            int ea;
            ea = elen(2, 40);
            kick(2, 40, 1'b1);
            repeat (ea + 9) @(negedge clk);
            kick(3, 30, 1'b1);
            repeat (elen(3, 30) + 2 * R * C + 3) @(negedge clk);
            end_window("R10 overlap");
        end

        finish_run();
    end
endmodule